// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block runs the refill of one cache line after a miss. When a miss arrives with the offset of the word the processor needs, it asks memory for that word first. Memory then returns the line one 8-byte beat at a time, starting at that word and wrapping past the end of the line back to its start. Each beat goes straight to the data-array write port and into a local copy of the line, and sets that word's valid bit.

The first beat is the word the processor stalled on. It is handed over one cycle after it arrives, together with a one-cycle restart pulse, so the processor continues while the other three beats are still coming in. During the fill, a processor access to a word that has already arrived (or is arriving in that cycle) hits at once. An access to a word still missing stalls the processor until the beat for that word lands. The line is reported fully valid only once all four beats are written. A second miss is refused until the current fill ends. Tag lookup and victim choice are handled elsewhere.

Top module: `cwf_refill`

## Requirements
- R1: A miss with `miss_valid` high while no fill is running is accepted in that same cycle: `mem_req_valid` is high with `mem_req_off` equal to `miss_off`, and `fill_busy` is high from the next cycle on.
- R2: Each beat with `mem_rsp_valid` high during a fill is written through in the same cycle (`arr_wr_en` high, `arr_wr_data` equal to `mem_rsp_data`). The indices follow the order start, start+1, ... modulo 4, where start is the accepted offset. A response while no fill is running writes nothing.
- R3: One cycle after the first beat of a fill, `cpu_restart` is high for exactly one cycle, `cpu_data_valid` is high, and `cpu_data` holds that beat.
- R4: `cpu_stall` is high from the cycle after acceptance until the cycle the critical word is delivered, and low in that delivery cycle unless an access is waiting.
- R5: Bit i of `word_valid` is set the cycle after the beat for word i is written. All bits are cleared the cycle after a miss is accepted.
- R6: `line_valid` goes high, and `fill_busy` goes low, the cycle after the fourth beat is written. `line_valid` is low during a fill.
- R7: A processor access (`cpu_rd_valid`, `cpu_rd_off`) to a word whose valid bit is set, or whose beat arrives in the same cycle, returns that word on `cpu_data` with `cpu_data_valid` high in the next cycle and does not raise `cpu_stall`.
- R8: An access during a fill to a word not yet present raises `cpu_stall` from the next cycle on. The word is delivered the cycle after its beat arrives, and the stall drops in that cycle. Further accesses are ignored while one is waiting.
- R9: A miss offered during a fill is ignored: `mem_req_valid` stays low, and neither `word_valid` nor the beat order changes.
- R10: An access while no fill is running, to a word whose valid bit is clear, produces no data and no stall.
- R11: After reset, `fill_busy`, `line_valid`, `word_valid`, `cpu_data_valid`, `cpu_restart` and `cpu_stall` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request for the line to be refilled |
| miss_off | input | 2 | Word offset of the missed word within the line |
| mem_req_valid | output | 1 | Fill request to memory |
| mem_req_off | output | 2 | Word that memory must return first |
| mem_rsp_valid | input | 1 | A response beat is present |
| mem_rsp_data | input | 64 | Response beat data |
| arr_wr_en | output | 1 | Data-array word write enable |
| arr_wr_idx | output | 2 | Word index being written |
| arr_wr_data | output | 64 | Word written to the array |
| word_valid | output | 4 | Per-word valid bits of the filling line |
| line_valid | output | 1 | All words of the line have been written |
| fill_busy | output | 1 | A fill is in progress |
| cpu_rd_valid | input | 1 | Processor access to the filling line |
| cpu_rd_off | input | 2 | Word offset of the processor access |
| cpu_data_valid | output | 1 | `cpu_data` carries a word for the processor |
| cpu_data | output | 64 | Word returned to the processor |
| cpu_restart | output | 1 | One-cycle pulse when the critical word is delivered |
| cpu_stall | output | 1 | Processor must wait |

## Verification
Fills are started at every one of the four offsets, so the wrap of the write indices is seen from each start point, including the case with no wrap at all. Processor accesses are tried in three forms: to a word already filled, to a word still missing, and to the word arriving in that same cycle. These separate the stored-data path, the pending-wait path and the forwarding path. Misses and responses offered at the wrong time check that nothing in the running fill is disturbed.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int WORD_W = 64;
    localparam int BEATS  = 4;
    localparam int OFF_W  = $clog2(BEATS);

    typedef logic [OFF_W-1:0]             off_t;
    typedef logic [WORD_W-1:0]            word_t;
    typedef logic [BEATS-1:0]             wmask_t;
    typedef logic [BEATS-1:0][WORD_W-1:0] line_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_CRIT = 2'd1,
        FS_BG   = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic valid;
        off_t off;
    } cpu_req_t;

    // Next beat index; BEATS is a power of two, so the width wraps it.
    function automatic off_t wrap_next(input off_t o);
        return o + off_t'(1);
    endfunction

    function automatic wmask_t off_mask(input off_t o);
        return wmask_t'(1) << o;
    endfunction

endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq
    import cwf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic miss_valid,
    input  off_t miss_off,
    input  logic rsp_valid,
    output logic accept,
    output logic busy,
    output logic crit_wait,
    output logic beat_fire,
    output off_t beat_idx,
    output logic first_beat,
    output logic last_beat
);

    fill_state_e state_q;
    off_t        idx_q;
    off_t        cnt_q;

    assign accept     = miss_valid && (state_q == FS_IDLE);
    assign busy       = (state_q != FS_IDLE);
    assign crit_wait  = (state_q == FS_CRIT);
    assign beat_fire  = rsp_valid && busy;
    assign beat_idx   = idx_q;
    assign first_beat = beat_fire && (state_q == FS_CRIT);
    assign last_beat  = beat_fire && (cnt_q == off_t'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (accept) begin
                        state_q <= FS_CRIT;
                        idx_q   <= miss_off;
                        cnt_q   <= '0;
                    end
                end
                FS_CRIT, FS_BG: begin
                    if (beat_fire) begin
                        idx_q   <= wrap_next(idx_q);
                        cnt_q   <= cnt_q + off_t'(1);
                        state_q <= last_beat ? FS_IDLE : FS_BG;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cwf_line_track.sv
module cwf_line_track
    import cwf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   beat_fire,
    input  off_t   beat_idx,
    input  word_t  beat_data,
    input  logic   last_beat,
    output wmask_t word_valid,
    output logic   line_full,
    output line_t  line_buf
);

    wmask_t wv_q;
    logic   full_q;
    line_t  buf_q;

    for (genvar g = 0; g < BEATS; g++) begin : g_word
        logic this_beat;
        assign this_beat = beat_fire && (beat_idx == off_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                wv_q[g]  <= 1'b0;
                buf_q[g] <= '0;
            end else if (accept) begin
                wv_q[g]  <= 1'b0;
            end else if (this_beat) begin
                wv_q[g]  <= 1'b1;
                buf_q[g] <= beat_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (accept) begin
            full_q <= 1'b0;
        end else if (last_beat) begin
            full_q <= 1'b1;
        end
    end

    assign word_valid = wv_q;
    assign line_full  = full_q;
    assign line_buf   = buf_q;

endmodule

// File: rtl/cwf_cpu_port.sv
module cwf_cpu_port
    import cwf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   busy,
    input  logic   crit_wait,
    input  logic   first_beat,
    input  logic   beat_fire,
    input  off_t   beat_idx,
    input  word_t  beat_data,
    input  wmask_t word_valid,
    input  line_t  line_buf,
    input  logic   rd_valid,
    input  off_t   rd_off,
    output logic   data_valid,
    output word_t  data,
    output logic   restart,
    output logic   stall
);

    cpu_req_t pend_q;
    logic     dv_q;
    word_t    data_q;
    logic     rs_q;

    wmask_t arriving;
    wmask_t avail;
    logic   take;
    logic   hit;
    logic   park;
    logic   serve;
    word_t  hit_word;

    assign arriving = beat_fire ? off_mask(beat_idx) : '0;
    assign avail    = word_valid | arriving;
    assign take     = rd_valid && !pend_q.valid;
    assign hit      = take && avail[rd_off];
    assign park     = take && !avail[rd_off] && busy;
    assign serve    = pend_q.valid && beat_fire && (beat_idx == pend_q.off);
    assign hit_word = word_valid[rd_off] ? line_buf[rd_off] : beat_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            dv_q   <= 1'b0;
            data_q <= '0;
            rs_q   <= 1'b0;
        end else begin
            rs_q <= first_beat;
            dv_q <= first_beat || hit || serve;
            if (first_beat || serve) begin
                data_q <= beat_data;
            end else if (hit) begin
                data_q <= hit_word;
            end
            if (serve) begin
                pend_q <= '0;
            end else if (park) begin
                pend_q <= '{valid: 1'b1, off: rd_off};
            end
        end
    end

    assign data_valid = dv_q;
    assign data       = data_q;
    assign restart    = rs_q;
    assign stall      = crit_wait || pend_q.valid;

endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
    import cwf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [OFF_W-1:0]  miss_off,
    output logic              mem_req_valid,
    output logic [OFF_W-1:0]  mem_req_off,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              arr_wr_en,
    output logic [OFF_W-1:0]  arr_wr_idx,
    output logic [WORD_W-1:0] arr_wr_data,
    output logic [BEATS-1:0]  word_valid,
    output logic              line_valid,
    output logic              fill_busy,
    input  logic              cpu_rd_valid,
    input  logic [OFF_W-1:0]  cpu_rd_off,
    output logic              cpu_data_valid,
    output logic [WORD_W-1:0] cpu_data,
    output logic              cpu_restart,
    output logic              cpu_stall
);

    logic   accept;
    logic   busy;
    logic   crit_wait;
    logic   beat_fire;
    off_t   beat_idx;
    logic   first_beat;
    logic   last_beat;
    wmask_t wv;
    logic   full;
    line_t  line_buf;

    cwf_beat_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .miss_off   (miss_off),
        .rsp_valid  (mem_rsp_valid),
        .accept     (accept),
        .busy       (busy),
        .crit_wait  (crit_wait),
        .beat_fire  (beat_fire),
        .beat_idx   (beat_idx),
        .first_beat (first_beat),
        .last_beat  (last_beat)
    );

    cwf_line_track u_track (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .beat_fire  (beat_fire),
        .beat_idx   (beat_idx),
        .beat_data  (mem_rsp_data),
        .last_beat  (last_beat),
        .word_valid (wv),
        .line_full  (full),
        .line_buf   (line_buf)
    );

    cwf_cpu_port u_cpu (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .crit_wait  (crit_wait),
        .first_beat (first_beat),
        .beat_fire  (beat_fire),
        .beat_idx   (beat_idx),
        .beat_data  (mem_rsp_data),
        .word_valid (wv),
        .line_buf   (line_buf),
        .rd_valid   (cpu_rd_valid),
        .rd_off     (cpu_rd_off),
        .data_valid (cpu_data_valid),
        .data       (cpu_data),
        .restart    (cpu_restart),
        .stall      (cpu_stall)
    );

    assign mem_req_valid = accept;
    assign mem_req_off   = miss_off;
    assign arr_wr_en     = beat_fire;
    assign arr_wr_idx    = beat_idx;
    assign arr_wr_data   = mem_rsp_data;
    assign word_valid    = wv;
    assign line_valid    = full;
    assign fill_busy     = busy;

endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk
    import cwf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req_valid,
    input logic              arr_wr_en,
    input logic [BEATS-1:0]  word_valid,
    input logic              line_valid,
    input logic              fill_busy,
    input logic              cpu_data_valid,
    input logic              cpu_restart
);

    // R1
    req_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> fill_busy);

    // R2
    write_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
        arr_wr_en |-> fill_busy);

    // R3
    restart_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_restart |-> cpu_data_valid);

    // R3
    restart_single_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_restart |=> !cpu_restart);

    // R5
    valid_only_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_busy && $past(fill_busy)) |->
            ((word_valid & $past(word_valid)) == $past(word_valid)));

    // R6
    full_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line_valid) |-> ($past(arr_wr_en) && !fill_busy && (&word_valid)));

    // R6
    not_full_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
        fill_busy |-> !line_valid);

    // R9
    no_req_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
        fill_busy |-> !mem_req_valid);

endmodule

bind cwf_refill cwf_refill_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .mem_req_valid  (mem_req_valid),
    .arr_wr_en      (arr_wr_en),
    .word_valid     (word_valid),
    .line_valid     (line_valid),
    .fill_busy      (fill_busy),
    .cpu_data_valid (cpu_data_valid),
    .cpu_restart    (cpu_restart)
);

// File: tb/cwf_refill_tb.sv
module cwf_refill_tb;
    import cwf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              miss_valid = 1'b0;
    logic [OFF_W-1:0]  miss_off = '0;
    logic              mem_req_valid;
    logic [OFF_W-1:0]  mem_req_off;
    logic              mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0] mem_rsp_data = '0;
    logic              arr_wr_en;
    logic [OFF_W-1:0]  arr_wr_idx;
    logic [WORD_W-1:0] arr_wr_data;
    logic [BEATS-1:0]  word_valid;
    logic              line_valid;
    logic              fill_busy;
    logic              cpu_rd_valid = 1'b0;
    logic [OFF_W-1:0]  cpu_rd_off = '0;
    logic              cpu_data_valid;
    logic [WORD_W-1:0] cpu_data;
    logic              cpu_restart;
    logic              cpu_stall;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cwf_refill u_dut (.*);

    function automatic logic [63:0] mdata(input int line, input int idx);
        return {32'hC0DE_0000 | 32'(line), 32'(idx) ^ 32'h5A5A_0000};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic start_miss(input int off);
        miss_valid = 1'b1;
        miss_off   = OFF_W'(off);
        #1;
        check(mem_req_valid == 1'b1, "R1 req", 64'(mem_req_valid), 64'd1);
        check(mem_req_off == OFF_W'(off), "R1 req_off", 64'(mem_req_off), 64'(off));
        tick();
        miss_valid = 1'b0;
        check(fill_busy == 1'b1, "R1 busy", 64'(fill_busy), 64'd1);
        check(cpu_stall == 1'b1, "R4 stall after accept", 64'(cpu_stall), 64'd1);
        check(word_valid == '0, "R5 cleared", 64'(word_valid), 64'd0);
        check(line_valid == 1'b0, "R6 low in fill", 64'(line_valid), 64'd0);
    endtask

    task automatic beat(input int line, input int idx);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mdata(line, idx);
        #1;
        check(arr_wr_en == 1'b1, "R2 wr_en", 64'(arr_wr_en), 64'd1);
        check(arr_wr_idx == OFF_W'(idx), "R2 wrap order", 64'(arr_wr_idx), 64'(idx));
        check(arr_wr_data == mdata(line, idx), "R2 wr_data", arr_wr_data, mdata(line, idx));
        tick();
        mem_rsp_valid = 1'b0;
        check(word_valid[idx] == 1'b1, "R5 bit set", 64'(word_valid), 64'(1 << idx));
    endtask

    task automatic t_reset();
        check(fill_busy == 1'b0, "R11 busy", 64'(fill_busy), 64'd0);
        check(line_valid == 1'b0, "R11 line_valid", 64'(line_valid), 64'd0);
        check(word_valid == '0, "R11 word_valid", 64'(word_valid), 64'd0);
        check(cpu_data_valid == 1'b0, "R11 data_valid", 64'(cpu_data_valid), 64'd0);
        check(cpu_restart == 1'b0, "R11 restart", 64'(cpu_restart), 64'd0);
        check(cpu_stall == 1'b0, "R11 stall", 64'(cpu_stall), 64'd0);
    endtask

    task automatic t_idle_access();
        cpu_rd_valid = 1'b1;
        cpu_rd_off   = 2'd1;
        tick();
        cpu_rd_valid = 1'b0;
        check(cpu_data_valid == 1'b0, "R10 no data", 64'(cpu_data_valid), 64'd0);
        check(cpu_stall == 1'b0, "R10 no stall", 64'(cpu_stall), 64'd0);
    endtask

    task automatic t_wrap(input int line, input int off);
        start_miss(off);
        tick();
        check(cpu_stall == 1'b1, "R4 stall waiting", 64'(cpu_stall), 64'd1);
        for (int k = 0; k < BEATS; k++) begin
            int idx;
            idx = (off + k) % BEATS;
            beat(line, idx);
            if (k == 0) begin
                check(cpu_restart == 1'b1, "R3 restart", 64'(cpu_restart), 64'd1);
                check(cpu_data_valid == 1'b1, "R3 data_valid", 64'(cpu_data_valid), 64'd1);
                check(cpu_data == mdata(line, idx), "R3 critical word", cpu_data,
                      mdata(line, idx));
                check(cpu_stall == 1'b0, "R4 released", 64'(cpu_stall), 64'd0);
            end else begin
                check(cpu_restart == 1'b0, "R3 single pulse", 64'(cpu_restart), 64'd0);
            end
            if (k < BEATS - 1) begin
                check(line_valid == 1'b0 && fill_busy == 1'b1, "R6 partial",
                      64'({line_valid, fill_busy}), 64'b01);
                tick();
            end else begin
                check(line_valid == 1'b1 && fill_busy == 1'b0, "R6 complete",
                      64'({line_valid, fill_busy}), 64'b10);
            end
        end
    endtask

    task automatic t_hit_and_stall();
        start_miss(2);
        beat(10, 2);
        beat(10, 3);
        cpu_rd_valid = 1'b1;
        cpu_rd_off   = 2'd3;
        tick();
        cpu_rd_valid = 1'b0;
        check(cpu_data_valid == 1'b1, "R7 hit valid", 64'(cpu_data_valid), 64'd1);
        check(cpu_data == mdata(10, 3), "R7 hit data", cpu_data, mdata(10, 3));
        check(cpu_stall == 1'b0, "R7 no stall", 64'(cpu_stall), 64'd0);
        cpu_rd_valid = 1'b1;
        cpu_rd_off   = 2'd1;
        tick();
        check(cpu_stall == 1'b1, "R8 stall", 64'(cpu_stall), 64'd1);
        check(cpu_data_valid == 1'b0, "R8 no data yet", 64'(cpu_data_valid), 64'd0);
        cpu_rd_off = 2'd3;
        tick();
        cpu_rd_valid = 1'b0;
        check(cpu_data_valid == 1'b0, "R8 second access ignored", 64'(cpu_data_valid), 64'd0);
        beat(10, 0);
        check(cpu_data_valid == 1'b0 && cpu_stall == 1'b1, "R8 other beat",
              64'({cpu_data_valid, cpu_stall}), 64'b01);
        beat(10, 1);
        check(cpu_data_valid == 1'b1, "R8 served", 64'(cpu_data_valid), 64'd1);
        check(cpu_data == mdata(10, 1), "R8 served data", cpu_data, mdata(10, 1));
        check(cpu_stall == 1'b0, "R8 stall drops", 64'(cpu_stall), 64'd0);
        check(line_valid == 1'b1, "R6 after stall fill", 64'(line_valid), 64'd1);
        cpu_rd_valid = 1'b1;
        cpu_rd_off   = 2'd0;
        tick();
        cpu_rd_valid = 1'b0;
        check(cpu_data == mdata(10, 0) && cpu_data_valid, "R7 full line hit", cpu_data,
              mdata(10, 0));
    endtask

    task automatic t_same_cycle();
        start_miss(1);
        beat(20, 1);
        cpu_rd_valid  = 1'b1;
        cpu_rd_off    = 2'd2;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mdata(20, 2);
        tick();
        cpu_rd_valid  = 1'b0;
        mem_rsp_valid = 1'b0;
        check(cpu_data_valid == 1'b1, "R7 forward valid", 64'(cpu_data_valid), 64'd1);
        check(cpu_data == mdata(20, 2), "R7 forward data", cpu_data, mdata(20, 2));
        check(cpu_stall == 1'b0, "R7 forward no stall", 64'(cpu_stall), 64'd0);
        beat(20, 3);
        beat(20, 0);
        check(line_valid == 1'b1, "R6 forward fill", 64'(line_valid), 64'd1);
    endtask

    task automatic t_busy_miss();
        start_miss(0);
        beat(30, 0);
        miss_valid = 1'b1;
        miss_off   = 2'd3;
        #1;
        check(mem_req_valid == 1'b0, "R9 no req", 64'(mem_req_valid), 64'd0);
        tick();
        miss_valid = 1'b0;
        check(word_valid == 4'b0001, "R9 valid kept", 64'(word_valid), 64'b0001);
        beat(30, 1);
        beat(30, 2);
        beat(30, 3);
        check(line_valid == 1'b1, "R9 fill completes", 64'(line_valid), 64'd1);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mdata(31, 0);
        #1;
        check(arr_wr_en == 1'b0, "R2 idle response ignored", 64'(arr_wr_en), 64'd0);
        tick();
        mem_rsp_valid = 1'b0;
        check(word_valid == 4'b1111 && line_valid, "R2 idle state kept",
              64'(word_valid), 64'hF);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_idle_access();
        for (int o = 0; o < BEATS; o++) begin
            t_wrap(o + 1, o);
            tick();
        end
        t_hit_and_stall();
        tick();
        t_same_cycle();
        tick();
        t_busy_miss();
        tick();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule